// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits at the end of a channel decoder. It takes decoded transport packets as a byte stream and drives them onto an output port with a clock, a data-valid strobe, a packet-sync pulse and a per-packet error flag. Bytes arrive over a valid/ready handshake. Each byte is marked with a start-of-packet bit, and the first byte of a packet carries an uncorrectable-error bit that applies to the whole packet. Packets are 188 bytes and open with a sync byte; the block follows the start-of-packet marker rather than counting bytes.

The port runs in one of two modes. In parallel mode a whole byte is presented on the 8-bit bus in each output clock period. In serial mode the byte is shifted out on bus bit 0, one bit per output clock period, most significant bit first, and the upstream source is stalled while the shift is in progress. The output clock runs at half the block clock. All outputs change while the output clock is low, so a receiver can sample on the rising edge. Separate configuration bits invert the clock, valid, sync and error outputs. A disable bit silences the port and discards incoming bytes.

Top module: `ts_out_fmt`

## Requirements
- R1: After reset the output clock, valid, sync and error outputs are low (no inversion selected), the data bus is zero, and `in_ready` is low until the first output slot.
- R2: The non-inverted output clock alternates every block clock cycle while enabled. Every output change happens on the block clock edge where the output clock falls, and the output clock rises one block clock cycle later.
- R3: In parallel mode (`cfg_serial`=0) each accepted byte appears on `ts_data[7:0]` for exactly one output clock period with valid high, in acceptance order. With a continuous supply, one byte is accepted every 2 block clock cycles.
- R4: In serial mode (`cfg_serial`=1) each accepted byte is sent on `ts_data[0]` over 8 consecutive output clock periods, bit 7 first. Valid is high in all 8 periods, and `ts_data[7:1]` is zero.
- R5: In serial mode `in_ready` stays low while a byte is being shifted out, so two accepted bytes are at least 16 block clock cycles apart.
- R6: In an output period with no byte (or bit) to send, valid is low, sync is low and the data bus keeps its previous value.
- R7: Sync is high only in the period that carries a start-of-packet byte (parallel) or the first bit of that byte (serial).
- R8: The error output takes the value of `in_err` from each start-of-packet byte. It holds that value for every period of the packet, including idle periods, until the next start-of-packet byte.
- R9: `cfg_inv_clk`, `cfg_inv_valid`, `cfg_inv_sync` and `cfg_inv_err` each invert only their own output. An idle port with valid and sync inversion shows both outputs high.
- R10: While `cfg_disable`=1 every output is driven low whatever the inversion bits, `in_ready` is high and accepted bytes are dropped. The internal state is cleared, so after re-enable the data bus and error flag restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Incoming packet byte |
| in_sop | input | 1 | Marks the first (sync) byte of a packet |
| in_err | input | 1 | Uncorrectable-packet flag, taken with the start-of-packet byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block takes the byte on this edge when valid |
| cfg_serial | input | 1 | 1 selects serial mode, 0 parallel |
| cfg_inv_clk | input | 1 | Invert output clock |
| cfg_inv_valid | input | 1 | Invert valid strobe |
| cfg_inv_sync | input | 1 | Invert sync pulse |
| cfg_inv_err | input | 1 | Invert error flag |
| cfg_disable | input | 1 | Turn the port off |
| ts_data | output | 8 | Output data bus (bit 0 only in serial mode) |
| ts_clk | output | 1 | Output clock |
| ts_valid | output | 1 | Data-valid strobe |
| ts_sync | output | 1 | Packet-sync pulse |
| ts_err | output | 1 | Packet error flag |

## Verification
A byte accepted on a block clock edge drives the data, valid, sync and error outputs from that same edge. The output clock rises one block clock cycle later, so the monitor looks for a rising output clock at each falling block clock edge and compares the bus there. `in_ready` depends only on registers and configuration, so the driver reads it at the falling edge before the accepting rising edge. Acceptance spacing is measured in simulation time between accepting edges. Configuration is changed 1 ns after a rising edge so that every sampling point sees settled values.

// File: rtl/ts_out_fmt.sv
module ts_out_fmt #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_err,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          cfg_serial,
  input  logic          cfg_inv_clk,
  input  logic          cfg_inv_valid,
  input  logic          cfg_inv_sync,
  input  logic          cfg_inv_err,
  input  logic          cfg_disable,
  output logic [DW-1:0] ts_data,
  output logic          ts_clk,
  output logic          ts_valid,
  output logic          ts_sync,
  output logic          ts_err
);
  localparam int CW = $clog2(DW);

  logic          phase_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] sh_q;
  logic [CW-1:0] bcnt_q;
  logic          v_q, s_q, e_q;
  logic          busy;

  assign busy     = cfg_serial && (bcnt_q != '0);
  assign in_ready = cfg_disable | (phase_q & ~busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      d_q     <= '0;
      sh_q    <= '0;
      bcnt_q  <= '0;
      v_q     <= 1'b0;
      s_q     <= 1'b0;
      e_q     <= 1'b0;
    end else if (cfg_disable) begin
      phase_q <= 1'b0;
      d_q     <= '0;
      sh_q    <= '0;
      bcnt_q  <= '0;
      v_q     <= 1'b0;
      s_q     <= 1'b0;
      e_q     <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (busy) begin
          d_q    <= {{(DW-1){1'b0}}, sh_q[DW-1]};
          sh_q   <= {sh_q[DW-2:0], 1'b0};
          bcnt_q <= bcnt_q - 1'b1;
          v_q    <= 1'b1;
          s_q    <= 1'b0;
        end else if (in_valid) begin
          v_q <= 1'b1;
          s_q <= in_sop;
          if (in_sop) e_q <= in_err;
          if (cfg_serial) begin
            d_q    <= {{(DW-1){1'b0}}, in_data[DW-1]};
            sh_q   <= {in_data[DW-2:0], 1'b0};
            bcnt_q <= CW'(DW-1);
          end else begin
            d_q <= in_data;
          end
        end else begin
          v_q <= 1'b0;
          s_q <= 1'b0;
        end
      end
    end
  end

  assign ts_data  = cfg_disable ? '0   : d_q;
  assign ts_clk   = ~cfg_disable & (phase_q ^ cfg_inv_clk);
  assign ts_valid = ~cfg_disable & (v_q ^ cfg_inv_valid);
  assign ts_sync  = ~cfg_disable & (s_q ^ cfg_inv_sync);
  assign ts_err   = ~cfg_disable & (e_q ^ cfg_inv_err);
endmodule

// File: rtl/ts_out_fmt_chk.sv
module ts_out_fmt_chk #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] in_data,
  input logic          in_sop,
  input logic          in_valid,
  input logic          in_ready,
  input logic          cfg_serial,
  input logic          cfg_disable,
  input logic          phase_q,
  input logic [DW-1:0] d_q,
  input logic [CW-1:0] bcnt_q,
  input logic          v_q,
  input logic          s_q,
  input logic          e_q
);
  logic take;
  assign take = in_valid && in_ready && !cfg_disable;

  assert_clk_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_disable && !phase_q) |=> phase_q);

  assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q) |-> $stable(d_q));

  assert_par_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cfg_serial) |=> (v_q && d_q == $past(in_data)));

  assert_ser_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cfg_serial) |=> (v_q && d_q[0] == $past(in_data[DW-1]) && d_q[DW-1:1] == '0));

  assert_ser_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cfg_serial) |=> (bcnt_q == CW'(DW-1)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q && !cfg_disable && !in_valid && (bcnt_q == '0 || !cfg_serial))
      |=> (!v_q && !s_q && $stable(d_q)));

  assert_sync_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_q |-> v_q);

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_disable && !(take && in_sop)) |=> $stable(e_q));

  assert_off_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_disable |=> (!v_q && !phase_q && bcnt_q == '0 && !e_q));
endmodule

bind ts_out_fmt ts_out_fmt_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_sop(in_sop),
  .in_valid(in_valid), .in_ready(in_ready), .cfg_serial(cfg_serial),
  .cfg_disable(cfg_disable), .phase_q(phase_q), .d_q(d_q),
  .bcnt_q(bcnt_q), .v_q(v_q), .s_q(s_q), .e_q(e_q)
);

// File: tb/ts_out_fmt_tb.sv
`timescale 1ns/1ps
module ts_out_fmt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_sop = 1'b0, in_err = 1'b0, in_valid = 1'b0;
  logic       in_ready;
  logic       cfg_serial = 1'b0, cfg_inv_clk = 1'b0, cfg_inv_valid = 1'b0;
  logic       cfg_inv_sync = 1'b0, cfg_inv_err = 1'b0, cfg_disable = 1'b0;
  logic [7:0] ts_data;
  logic       ts_clk, ts_valid, ts_sync, ts_err;

  always #2 clk = ~clk;

  ts_out_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_sop(in_sop),
    .in_err(in_err), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_serial(cfg_serial), .cfg_inv_clk(cfg_inv_clk),
    .cfg_inv_valid(cfg_inv_valid), .cfg_inv_sync(cfg_inv_sync),
    .cfg_inv_err(cfg_inv_err), .cfg_disable(cfg_disable),
    .ts_data(ts_data), .ts_clk(ts_clk), .ts_valid(ts_valid),
    .ts_sync(ts_sync), .ts_err(ts_err)
  );

  int checks = 0, errors = 0;
  bit done = 0, mon_en = 0, prev_raw = 0;
  logic [7:0] qd[$];
  bit qs[$], qe[$];
  logic [7:0] last_d = '0;
  bit last_e = 0, cur_err = 0;
  longint last_acc = -1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ser_bit(input logic [7:0] b, input int i);
    return {7'b0, b[7-i]};
  endfunction

  task automatic send(input logic [7:0] d, input bit sop, input bit err, input int gap);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
    in_data = d; in_sop = sop; in_err = err; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    if (!cfg_disable) begin
      if (sop) cur_err = err;
      if (last_acc >= 0 && cfg_serial)
        chk(($time - last_acc) >= 64, "R5 serial accept spacing", 32'($time - last_acc), 64);
      if (last_acc >= 0 && !cfg_serial && gap == 0)
        chk(($time - last_acc) == 8, "R3 parallel back-to-back spacing", 32'($time - last_acc), 8);
      last_acc = $time;
      if (cfg_serial) begin
        for (int i = 0; i < 8; i++) begin
          qd.push_back(ser_bit(d, i)); qs.push_back(sop && i == 0); qe.push_back(cur_err);
        end
      end else begin
        qd.push_back(d); qs.push_back(sop); qe.push_back(cur_err);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_err = 1'b0;
  endtask

  task automatic packet(input int n, input bit err, input int gapmax);
    for (int k = 0; k < n; k++) begin
      int g;
      g = (gapmax == 0) ? 0 : int'($urandom % (gapmax + 1));
      send(k == 0 ? 8'h47 : 8'($urandom), k == 0, err, g);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (qd.size() != 0 && t < 20000) begin @(negedge clk); t++; end
    chk(qd.size() == 0, "R3 all accepted units emitted", qd.size(), 0);
    repeat (4) @(negedge clk);
    last_acc = -1;
  endtask

  task automatic unit();
    bit v, s, e;
    v = ts_valid ^ cfg_inv_valid;
    s = ts_sync ^ cfg_inv_sync;
    e = ts_err ^ cfg_inv_err;
    if (v) begin
      if (qd.size() == 0) begin
        chk(1'b0, "R6 valid with nothing accepted", 1, 0);
      end else begin
        logic [7:0] xd; bit xs, xe;
        xd = qd.pop_front(); xs = qs.pop_front(); xe = qe.pop_front();
        chk(ts_data == xd, cfg_serial ? "R4 serial bit" : "R3 parallel byte", ts_data, xd);
        chk(s == xs, "R7 sync pulse", s, xs);
        chk(e == xe, "R8 packet error flag", e, xe);
        last_d = xd; last_e = xe;
      end
    end else begin
      chk(ts_data == last_d, "R6 idle data hold", ts_data, last_d);
      chk(!s, "R6 idle sync low", s, 0);
      chk(e == last_e, "R8 error held when idle", e, last_e);
    end
  endtask

  always @(negedge clk) begin
    if (!mon_en || cfg_disable || !rst_n) prev_raw = 0;
    else begin
      bit raw;
      raw = ts_clk ^ cfg_inv_clk;
      if (raw && !prev_raw) unit();
      prev_raw = raw;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk(ts_clk == 0 && ts_valid == 0 && ts_sync == 0 && ts_err == 0, "R1 reset strobes",
        {ts_clk, ts_valid, ts_sync, ts_err}, 0);
    chk(ts_data == 0, "R1 reset data", ts_data, 0);
    chk(in_ready == 0, "R1 reset ready", in_ready, 0);
    mon_en = 1;
    @(posedge clk); #1;
    chk(ts_clk == 1, "R2 output clock high one cycle after reset", ts_clk, 1);
    @(posedge clk); #1;
    chk(ts_clk == 0, "R2 output clock toggles", ts_clk, 0);
    @(negedge clk);

    packet(188, 0, 0);
    packet(188, 1, 3);
    packet(20, 0, 5);
    drain();

    @(posedge clk); #1;
    cfg_inv_clk = 1; cfg_inv_valid = 1; cfg_inv_sync = 1; cfg_inv_err = 1;
    @(negedge clk);
    chk(ts_valid == 1, "R9 inverted idle valid", ts_valid, 1);
    chk(ts_sync == 1, "R9 inverted idle sync", ts_sync, 1);
    chk(ts_err == ~last_e, "R9 inverted error", ts_err, ~last_e);
    packet(60, 1, 4);
    drain();
    @(posedge clk); #1;
    cfg_inv_clk = 0; cfg_inv_valid = 0; cfg_inv_sync = 0; cfg_inv_err = 0;
    cfg_serial = 1;
    @(negedge clk);

    packet(188, 0, 2);
    packet(40, 1, 4);
    drain();
    @(posedge clk); #1;
    cfg_inv_clk = 1; cfg_inv_err = 1;
    @(negedge clk);
    packet(30, 0, 3);
    send(8'h80, 1, 1, 0);
    send(8'h01, 0, 0, 0);
    drain();

    @(posedge clk); #1;
    cfg_inv_valid = 1; cfg_inv_sync = 1;
    cfg_disable = 1;
    @(negedge clk);
    chk(ts_data == 0 && ts_clk == 0, "R10 disabled data and clock", {ts_data, ts_clk}, 0);
    chk(ts_valid == 0 && ts_sync == 0 && ts_err == 0, "R10 disabled strobes low",
        {ts_valid, ts_sync, ts_err}, 0);
    chk(in_ready == 1, "R10 disabled ready high", in_ready, 1);
    send(8'h47, 1, 1, 0);
    send(8'hA5, 0, 0, 0);
    send(8'h5A, 0, 0, 1);
    chk(ts_valid == 0 && ts_data == 0, "R10 dropped bytes not shown", {ts_valid, ts_data}, 0);
    @(posedge clk); #1;
    cfg_disable = 0; cfg_inv_clk = 0; cfg_inv_valid = 0; cfg_inv_sync = 0; cfg_inv_err = 0;
    cfg_serial = 0;
    last_d = '0; last_e = 0;
    @(negedge clk);
    repeat (6) @(negedge clk);
    chk(ts_data == 0 && ts_err == 0, "R10 state cleared after re-enable", {ts_data, ts_err}, 0);
    chk(qd.size() == 0, "R10 no dropped byte emitted", qd.size(), 0);
    packet(25, 1, 2);
    packet(10, 0, 0);
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule